// File: doc/BRIEF.md
# Boot Loader Control Register with Protected Address Bits

This block holds the 32-bit control word that steers the boot loader. The word carries the serial device address, the starting peripheral (memory) address, the peripheral address size, the address increment setting, the page mode, a chain request bit and an unlock bit. Two writers can update it. A host bus writes it during normal operation. The boot loader sequencer writes it while it loads registers, for example to redirect itself to another memory device or another region.

All fields take the written value on every write, except the lowest two bits of the device address. Those bits are loaded from strap inputs during reset. After reset they change only when the unlock bit was already set before the write. A write that sets the unlock bit opens them for the next write, not for itself. Moving the loader to a device whose low address bits differ therefore takes two writes: one that sets the unlock bit, then one that carries the new address.

All fields leave the block as separate outputs for the sequencer, and the whole word is available as one read value.

Top module: `bootctl_reg`

## Requirements
- R1: During reset (`rstN` low at a rising clock edge) the register loads these values. The upper device-address bits take parameter `DEV_RST_HI`. The protected low bits take `strapLo`. All other fields, including chain and unlock, become 0.
- R2: A write updates the peripheral address, the upper device-address bits, size, increment, page mode, chain and unlock fields at the next rising edge.
- R3: When the unlock bit was 0 before a write, the protected low device-address bits keep their value. This holds even if the same write sets the unlock bit.
- R4: When the unlock bit was 1 before a write, the protected low device-address bits take the written value.
- R5: A write with the unlock bit set, followed by a write of a new device address, changes the protected bits to the new value.
- R6: When host and sequencer write in the same cycle, the sequencer data is stored and the host data is discarded.
- R7: In a cycle with no write, every field holds its value.
- R8: Word layout. Bits [15:0] hold the peripheral address. Bits [22:16] hold the device address, with bits [17:16] protected. Bits [27:26] hold the page mode. Bit 28 is increment, bit 29 is size, bit 30 is unlock and bit 31 is chain. Bits [25:23] are unused: they ignore writes and read 0.
- R9: Each field output equals the matching bits of `regQ` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapLo | input | 2 | Reset value of the protected device-address bits |
| hostWe | input | 1 | Host write strobe |
| hostWdata | input | 32 | Host write word |
| seqWe | input | 1 | Sequencer write strobe |
| seqWdata | input | 32 | Sequencer write word |
| regQ | output | 32 | Current register word |
| devAddr | output | 7 | Device address |
| periphAddr | output | 16 | Starting peripheral address |
| addrSize | output | 1 | Peripheral address size select |
| addrIncr | output | 1 | Address increment select |
| pageMode | output | 2 | Page mode |
| chainEn | output | 1 | Chain request |
| unlockEn | output | 1 | Unlock for protected bits |

## Verification
The bench uses the default widths: a 7-bit device address with two protected bits, a 16-bit peripheral address, and `DEV_RST_HI` set to 5'b10100. It applies reset twice, with two different strap patterns, so both values of each protected bit are seen coming from the straps. Random traffic from both writers sets and clears the unlock bit freely. This produces protected writes, unprotected writes and simultaneous writes from host and sequencer in every order.

// File: rtl/bootctl_pkg.sv
package bootctl_pkg;
  localparam int WORD_W    = 32;
  localparam int CHAIN_BIT = 31;
  localparam int UNLK_BIT  = 30;
  localparam int SIZE_BIT  = 29;
  localparam int INCR_BIT  = 28;
  localparam int PMODE_LSB = 26;
  localparam int PMODE_W   = 2;

  typedef struct packed {
    logic load;     // a write happens this cycle
    logic useSeq;   // take sequencer data
    logic lowOpen;  // protected bits may change
  } strobe_t;
endpackage

// File: rtl/bootctl_ctrl.sv
module bootctl_ctrl
  import bootctl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostWe,
  input  logic    seqWe,
  input  logic    unlockQ,
  output strobe_t stb
);
  always_comb begin
    stb.load    = rstN & (hostWe | seqWe);
    stb.useSeq  = seqWe;
    stb.lowOpen = unlockQ;
  end

  // R7
  idle_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWe && !seqWe) |-> !stb.load);
endmodule

// File: rtl/bootctl_dp.sv
module bootctl_dp
  import bootctl_pkg::*;
#(
  parameter int DEV_W      = 7,
  parameter int PADDR_W    = 16,
  parameter int LOCK_W     = 2,
  parameter logic [DEV_W-LOCK_W-1:0] DEV_RST_HI = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LOCK_W-1:0]  strapLo,
  input  logic [WORD_W-1:0]  hostWdata,
  input  logic [WORD_W-1:0]  seqWdata,
  input  strobe_t            stb,
  output logic [WORD_W-1:0]  regQ,
  output logic [DEV_W-1:0]   devAddr,
  output logic [PADDR_W-1:0] periphAddr,
  output logic               addrSize,
  output logic               addrIncr,
  output logic [PMODE_W-1:0] pageMode,
  output logic               chainEn,
  output logic               unlockEn
);
  localparam int HI_W    = DEV_W - LOCK_W;
  localparam int DEV_LSB = PADDR_W;
  localparam int HI_LSB  = DEV_LSB + LOCK_W;
  localparam int DEV_TOP = DEV_LSB + DEV_W;

  logic [WORD_W-1:0]  wData;
  logic [HI_W-1:0]    devHiQ;
  logic [LOCK_W-1:0]  devLoQ;
  logic [PADDR_W-1:0] pAddrQ;
  logic               sizeQ, incrQ, chainQ, unlkQ;
  logic [PMODE_W-1:0] pmodeQ;

  assign wData = stb.useSeq ? seqWdata : hostWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devHiQ <= DEV_RST_HI;
      devLoQ <= strapLo;
      pAddrQ <= '0;
      sizeQ  <= 1'b0;
      incrQ  <= 1'b0;
      pmodeQ <= '0;
      chainQ <= 1'b0;
      unlkQ  <= 1'b0;
    end else if (stb.load) begin
      devHiQ <= wData[HI_LSB +: HI_W];
      pAddrQ <= wData[0 +: PADDR_W];
      sizeQ  <= wData[SIZE_BIT];
      incrQ  <= wData[INCR_BIT];
      pmodeQ <= wData[PMODE_LSB +: PMODE_W];
      chainQ <= wData[CHAIN_BIT];
      unlkQ  <= wData[UNLK_BIT];
      if (stb.lowOpen) devLoQ <= wData[DEV_LSB +: LOCK_W];
    end
  end

  always_comb begin
    regQ = '0;
    regQ[0 +: PADDR_W]      = pAddrQ;
    regQ[DEV_LSB +: LOCK_W] = devLoQ;
    regQ[HI_LSB +: HI_W]    = devHiQ;
    regQ[PMODE_LSB +: PMODE_W] = pmodeQ;
    regQ[INCR_BIT]  = incrQ;
    regQ[SIZE_BIT]  = sizeQ;
    regQ[UNLK_BIT]  = unlkQ;
    regQ[CHAIN_BIT] = chainQ;
  end

  assign devAddr    = {devHiQ, devLoQ};
  assign periphAddr = pAddrQ;
  assign addrSize   = sizeQ;
  assign addrIncr   = incrQ;
  assign pageMode   = pmodeQ;
  assign chainEn    = chainQ;
  assign unlockEn   = unlkQ;

  // R3
  low_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !unlkQ) |=> $stable(devLoQ));
  // R4
  low_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && unlkQ) |=> devLoQ == $past(wData[DEV_LSB +: LOCK_W]));
  // R2
  unlock_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> unlkQ == $past(wData[UNLK_BIT]));
  // R7
  hold_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(regQ));
  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regQ[PMODE_LSB-1:DEV_TOP] == '0);
endmodule

// File: rtl/bootctl_reg.sv
module bootctl_reg
  import bootctl_pkg::*;
#(
  parameter int DEV_W      = 7,
  parameter int PADDR_W    = 16,
  parameter int LOCK_W     = 2,
  parameter logic [DEV_W-LOCK_W-1:0] DEV_RST_HI = 5'b10100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LOCK_W-1:0]  strapLo,
  input  logic               hostWe,
  input  logic [31:0]        hostWdata,
  input  logic               seqWe,
  input  logic [31:0]        seqWdata,
  output logic [31:0]        regQ,
  output logic [DEV_W-1:0]   devAddr,
  output logic [PADDR_W-1:0] periphAddr,
  output logic               addrSize,
  output logic               addrIncr,
  output logic [1:0]         pageMode,
  output logic               chainEn,
  output logic               unlockEn
);
  localparam int HI_LSB = PADDR_W + LOCK_W;
  localparam int HI_W   = DEV_W - LOCK_W;

  strobe_t stb;

  bootctl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .seqWe(seqWe),
    .unlockQ(unlockEn), .stb(stb)
  );

  bootctl_dp #(
    .DEV_W(DEV_W), .PADDR_W(PADDR_W), .LOCK_W(LOCK_W), .DEV_RST_HI(DEV_RST_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strapLo(strapLo),
    .hostWdata(hostWdata), .seqWdata(seqWdata), .stb(stb),
    .regQ(regQ), .devAddr(devAddr), .periphAddr(periphAddr),
    .addrSize(addrSize), .addrIncr(addrIncr), .pageMode(pageMode),
    .chainEn(chainEn), .unlockEn(unlockEn)
  );

  // R6
  seq_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && seqWe) |=> devAddr[DEV_W-1:LOCK_W] == $past(seqWdata[HI_LSB +: HI_W]));
  // R9
  field_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    periphAddr == regQ[PADDR_W-1:0] && chainEn == regQ[31]);
endmodule

// File: tb/sim_bootctl_reg.sv
`timescale 1ns/1ps
module sim_bootctl_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  strapLo = 2'b10;
  logic        hostWe = 1'b0, seqWe = 1'b0;
  logic [31:0] hostWdata = '0, seqWdata = '0;
  logic [31:0] regQ;
  logic [6:0]  devAddr;
  logic [15:0] periphAddr;
  logic        addrSize, addrIncr, chainEn, unlockEn;
  logic [1:0]  pageMode;

  int nChecks = 0, nFails = 0;
  logic [31:0] expWord;

  always #10 clk = ~clk;

  bootctl_reg u0 (
    .clk(clk), .rstN(rstN), .strapLo(strapLo),
    .hostWe(hostWe), .hostWdata(hostWdata), .seqWe(seqWe), .seqWdata(seqWdata),
    .regQ(regQ), .devAddr(devAddr), .periphAddr(periphAddr),
    .addrSize(addrSize), .addrIncr(addrIncr), .pageMode(pageMode),
    .chainEn(chainEn), .unlockEn(unlockEn)
  );

  // expected word after a write, from R2..R4, R6, R8
  function automatic logic [31:0] nextWord(logic [31:0] cur, logic [31:0] wd);
    logic [31:0] n;
    n = wd & 32'hFC7F_FFFF;
    if (!cur[30]) n[17:16] = cur[17:16];
    return n;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkFields(string req);
    check(req, regQ, expWord);
    // R9
    check({req, "/R9"}, {9'd0, devAddr, periphAddr},
          {9'd0, regQ[22:16], regQ[15:0]});
    check({req, "/R9"}, {26'd0, chainEn, unlockEn, addrSize, addrIncr, pageMode},
          {26'd0, regQ[31], regQ[30], regQ[29], regQ[28], regQ[27:26]});
  endtask

  task automatic doCycle(logic h, logic [31:0] hd, logic s, logic [31:0] sd, string req);
    hostWe = h; hostWdata = hd; seqWe = s; seqWdata = sd;
    if (h || s) expWord = nextWord(expWord, s ? sd : hd);
    @(negedge clk);
    hostWe = 1'b0; seqWe = 1'b0;
    checkFields(req);
  endtask

  task automatic doReset(logic [1:0] st);
    strapLo = st; rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    expWord = {16'h0000, 16'h0000};
    expWord[22:18] = 5'b10100;
    expWord[17:16] = st;
    checkFields("R1");
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5731));
    @(negedge clk);
    doReset(2'b10);
    // R7: idle cycles hold
    doCycle(0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, "R7");
    // R3: write sets unlock but low bits stay
    doCycle(1, 32'h4005_1234, 0, 0, "R3");
    check("R3", {30'd0, devAddr[1:0]}, 32'd2);
    // R4: unlock was set, low bits move
    doCycle(1, 32'h0009_5678, 0, 0, "R4");
    check("R4", {30'd0, devAddr[1:0]}, 32'd1);
    // R3: now locked again
    doCycle(1, 32'h0002_0000, 0, 0, "R3");
    check("R3", {30'd0, devAddr[1:0]}, 32'd1);
    // R5: two-step change to 3
    doCycle(0, 0, 1, 32'h4000_0000, "R5");
    doCycle(0, 0, 1, 32'hBFFF_FFFF, "R5");
    check("R5", {30'd0, devAddr[1:0]}, 32'd3);
    // R8: all ones, unused bits read 0
    doCycle(1, 32'hFFFF_FFFF, 0, 0, "R8");
    check("R8", {29'd0, regQ[25:23]}, 32'd0);
    // R6: simultaneous writes
    doCycle(1, 32'h0000_0000, 1, 32'h2A4C_BEEF, "R6");
    doReset(2'b01);
    for (int i = 0; i < 400; i++) begin
      logic h, s;
      logic [31:0] hd, sd;
      h = ($urandom % 3) != 0;
      s = ($urandom % 3) == 0;
      hd = $urandom; sd = $urandom;
      if (h && s) doCycle(h, hd, s, sd, "R6");
      else if (!h && !s) doCycle(h, hd, s, sd, "R7");
      else if (expWord[30]) doCycle(h, hd, s, sd, "R4");
      else doCycle(h, hd, s, sd, "R3");
    end
    doCycle(1, 32'h1234_5678, 0, 0, "R2");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule